// File: doc/BRIEF.md
# Delay-Locked Loop Start-Up and Relock Sequencer

This block decides when a memory device's delay-locked loop may be considered locked and when the device may accept commands. It runs on a fast, free-running monitor clock. The device's reference clock enters as a plain data input. The block samples that input through a synchronizer and looks for its rising edges. It counts reference cycles towards lock, and it restarts the count when any of the following happens: the loop is disabled, the reference clock goes silent, a frequency change is announced, or the measured reference period is too long for the loop to follow.

A second counter tracks reference cycles that carry no read. Output impedance is only declared settled once enough of those quiet cycles have passed. The analog loop, the supply ramp and the pad drivers lie outside the block. Lock is modelled purely as a cycle count.

Top module: `dll_relock_seq`

## Requirements
- R1: While `dllRun` is low, the lock count is held at zero, so `lockReady` stays low.
- R2: `lockReady` goes high once LOCK_CYCLES (1024) reference rising edges have been seen with no clearing condition present. The count then saturates and `lockReady` stays high until a clearing condition appears.
- R3: When STOP_TICKS (8) monitor cycles pass without a reference rising edge, the clock counts as absent. The lock count clears, and a fresh run of 1024 edges is needed after the clock returns.
- R4: A one-cycle `freqChange` pulse clears the lock count, and 1024 further edges are needed to relock.
- R5: `refClkIn` passes through a two-stage synchronizer. An edge is recognised when the synchronized value is 1 and its previous value was 0. After reset the clock counts as absent until the first edge is seen.
- R6: `impCalDone` goes high after IMP_CYCLES (1024) reference edges during which `readCycle` was low. Edges seen with `readCycle` high do not advance this count. Loop resets do not clear it; only `rst` does.
- R7: At each reference edge, `periodTooLong` is updated to show whether the number of monitor ticks since the previous edge exceeded MAX_PERIOD_TICKS (2). It holds that value until the next edge. While it is high, the lock count is cleared.
- R8: `cmdEnable` is high only when `lockReady` is high and no clearing condition (`dllRun` low, clock absent, `freqChange`, `periodTooLong`) is present in the same cycle.
- R9: With `rst` high, all four outputs are low on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast monitor clock |
| rst | input | 1 | Synchronous reset, active high |
| refClkIn | input | 1 | Reference clock, sampled as data |
| dllRun | input | 1 | Low holds the loop off |
| freqChange | input | 1 | One-cycle strobe announcing a new operating frequency |
| readCycle | input | 1 | High when the current reference cycle is a read |
| lockReady | output | 1 | Loop counted as locked |
| cmdEnable | output | 1 | Commands may be accepted |
| impCalDone | output | 1 | Output impedance settled |
| periodTooLong | output | 1 | Last measured reference period is outside the lock range |

## Verification
The assertions check, on every cycle, that each clearing cause (loop off, clock absent, frequency change) drops `lockReady` on the next clock. They also check that lock and the slow-period flag can only rise right after a reference edge, that `impCalDone` never falls, and that `cmdEnable` is never high during a frequency strobe.

The exact moment lock is reached, the saturation of the count, the way reads are excluded from the impedance count, and relock after a stopped or slow clock can only be shown by the bench's scenarios. The bench compares them against its cycle model.

// File: rtl/dllseq_pkg.sv
`timescale 1ns/1ps
package dllseq_pkg;
  typedef struct packed {
    logic refEdge;
    logic clkAbsent;
    logic slowPeriod;
    logic lockFull;
    logic impFull;
  } dpStatus_t;

  typedef struct packed {
    logic clrLock;
    logic incLock;
    logic incImp;
  } ctlStrobe_t;
endpackage

// File: rtl/dllseq_datapath.sv
`timescale 1ns/1ps
module dllseq_datapath
  import dllseq_pkg::*;
#(
  parameter int LOCK_CYCLES      = 1024,
  parameter int IMP_CYCLES       = 1024,
  parameter int STOP_TICKS       = 8,
  parameter int MAX_PERIOD_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       refClkIn,
  input  ctlStrobe_t strobe,
  output dpStatus_t  status
);
  localparam int LOCK_W = $clog2(LOCK_CYCLES + 1);
  localparam int IMP_W  = $clog2(IMP_CYCLES + 1);
  localparam int GAP_W  = $clog2(STOP_TICKS + 1);
  localparam logic [LOCK_W-1:0] LOCK_MAX = LOCK_W'(LOCK_CYCLES);
  localparam logic [IMP_W-1:0]  IMP_MAX  = IMP_W'(IMP_CYCLES);
  localparam logic [GAP_W-1:0]  GAP_MAX  = GAP_W'(STOP_TICKS);

  logic refMeta, refSync, refPrev;
  logic refEdge;
  logic [GAP_W-1:0]  gapCnt;
  logic [LOCK_W-1:0] lockCnt;
  logic [IMP_W-1:0]  impCnt;
  logic slowPeriod;
  logic [31:0] periodTicks;

  // synchronizer and edge detector for the sampled reference clock
  always_ff @(posedge clk) begin
    if (rst) begin
      refMeta <= 1'b0;
      refSync <= 1'b0;
      refPrev <= 1'b0;
    end else begin
      refMeta <= refClkIn;
      refSync <= refMeta;
      refPrev <= refSync;
    end
  end
  assign refEdge = refSync & ~refPrev;

  // ticks since the last reference edge, saturating at the stop limit
  always_ff @(posedge clk) begin
    if (rst)                  gapCnt <= GAP_MAX;
    else if (refEdge)         gapCnt <= '0;
    else if (gapCnt < GAP_MAX) gapCnt <= gapCnt + 1'b1;
  end

  assign periodTicks = 32'(gapCnt) + 32'd1;

  always_ff @(posedge clk) begin
    if (rst)          slowPeriod <= 1'b0;
    else if (refEdge) slowPeriod <= (periodTicks > 32'(MAX_PERIOD_TICKS));
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clrLock) lockCnt <= '0;
    else if (strobe.incLock)   lockCnt <= lockCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                impCnt <= '0;
    else if (strobe.incImp) impCnt <= impCnt + 1'b1;
  end

  assign status.refEdge    = refEdge;
  assign status.clkAbsent  = (gapCnt == GAP_MAX);
  assign status.slowPeriod = slowPeriod;
  assign status.lockFull   = (lockCnt == LOCK_MAX);
  assign status.impFull    = (impCnt == IMP_MAX);

  // R2: lock can only be reached one clock after an edge was counted
  a_r2_lock_after_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(status.lockFull) |-> $past(refEdge));
  // R7: the period flag changes only at a reference edge
  a_r7_slow_on_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(slowPeriod) |-> $past(refEdge));
  // R6: impedance settlement is never withdrawn
  a_r6_imp_sticky: assert property (@(posedge clk) disable iff (rst)
    status.impFull |=> status.impFull);
endmodule

// File: rtl/dllseq_control.sv
`timescale 1ns/1ps
module dllseq_control
  import dllseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dllRun,
  input  logic       freqChange,
  input  logic       readCycle,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       cmdEnable
);
  logic clearCause;

  always_comb begin
    clearCause     = !dllRun || status.clkAbsent || freqChange || status.slowPeriod;
    strobe.clrLock = clearCause;
    strobe.incLock = status.refEdge && !status.lockFull;
    strobe.incImp  = status.refEdge && !readCycle && !status.impFull;
    cmdEnable      = status.lockFull && !clearCause;
  end

  // R8: no command window while a frequency change is announced
  a_r8_no_cmd_on_freq: assert property (@(posedge clk) disable iff (rst)
    freqChange |-> !cmdEnable);
  // R1: a disabled loop never keeps lock past the next clock
  a_r1_off_drops_lock: assert property (@(posedge clk) disable iff (rst)
    !dllRun |=> !status.lockFull);
endmodule

// File: rtl/dll_relock_seq.sv
`timescale 1ns/1ps
module dll_relock_seq
  import dllseq_pkg::*;
#(
  parameter int LOCK_CYCLES      = 1024,
  parameter int IMP_CYCLES       = 1024,
  parameter int STOP_TICKS       = 8,
  parameter int MAX_PERIOD_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic refClkIn,
  input  logic dllRun,
  input  logic freqChange,
  input  logic readCycle,
  output logic lockReady,
  output logic cmdEnable,
  output logic impCalDone,
  output logic periodTooLong
);
  dpStatus_t  status;
  ctlStrobe_t strobe;

  dllseq_datapath #(
    .LOCK_CYCLES(LOCK_CYCLES), .IMP_CYCLES(IMP_CYCLES),
    .STOP_TICKS(STOP_TICKS), .MAX_PERIOD_TICKS(MAX_PERIOD_TICKS)
  ) u_datapath (
    .clk(clk), .rst(rst), .refClkIn(refClkIn), .strobe(strobe), .status(status)
  );

  dllseq_control u_control (
    .clk(clk), .rst(rst), .dllRun(dllRun), .freqChange(freqChange),
    .readCycle(readCycle), .status(status), .strobe(strobe), .cmdEnable(cmdEnable)
  );

  assign lockReady     = status.lockFull;
  assign impCalDone    = status.impFull;
  assign periodTooLong = status.slowPeriod;

  // R3: a silent reference clock forces the lock count back to zero
  a_r3_absent_clears: assert property (@(posedge clk) disable iff (rst)
    status.clkAbsent |=> !lockReady);
  // R4: a frequency change strobe drops lock on the next clock
  a_r4_freq_clears: assert property (@(posedge clk) disable iff (rst)
    freqChange |=> !lockReady);
endmodule

// File: tb/dll_relock_seq_bench.sv
`timescale 1ns/1ps
module dll_relock_seq_bench;
  localparam int LOCKN = 1024;
  localparam int IMPN  = 1024;
  localparam int STOPN = 8;
  localparam int MAXP  = 2;

  logic clk = 1'b0;
  logic rst, refClkIn, dllRun, freqChange, readCycle;
  logic lockReady, cmdEnable, impCalDone, periodTooLong;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dll_relock_seq u_dll_relock_seq (
    .clk(clk), .rst(rst), .refClkIn(refClkIn), .dllRun(dllRun),
    .freqChange(freqChange), .readCycle(readCycle), .lockReady(lockReady),
    .cmdEnable(cmdEnable), .impCalDone(impCalDone), .periodTooLong(periodTooLong)
  );

  // behavioural reference model
  int hist [3];
  int mGap, mLock, mImp;
  bit mSlow;
  always @(posedge clk) begin
    bit edgeSeen, clr;
    edgeSeen = (hist[1] == 1) && (hist[2] == 0);
    clr = !dllRun || (mGap >= STOPN) || freqChange || mSlow;
    if (rst) begin
      hist[0] <= 0; hist[1] <= 0; hist[2] <= 0;
      mGap <= STOPN; mSlow <= 0; mLock <= 0; mImp <= 0;
    end else begin
      hist[0] <= int'(refClkIn); hist[1] <= hist[0]; hist[2] <= hist[1];
      mGap <= edgeSeen ? 0 : (mGap < STOPN ? mGap + 1 : mGap);
      if (edgeSeen) mSlow <= (mGap + 1 > MAXP);
      if (clr) mLock <= 0;
      else if (edgeSeen && mLock < LOCKN) mLock <= mLock + 1;
      if (edgeSeen && !readCycle && mImp < IMPN) mImp <= mImp + 1;
    end
  end

  task automatic check(string req, logic got, logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %0b expected %0b", req, $time, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit clr;
      clr = !dllRun || (mGap >= STOPN) || freqChange || mSlow;
      check("R2 lockReady model", lockReady, mLock == LOCKN);
      check("R8 cmdEnable model", cmdEnable, (mLock == LOCKN) && !clr);
      check("R6 impCalDone model", impCalDone, mImp == IMPN);
      check("R7 periodTooLong model", periodTooLong, mSlow);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic refCycles(int n, int hiT, int loT);
    for (int i = 0; i < n; i++) begin
      refClkIn = 1'b1; repeat (hiT) tick();
      refClkIn = 1'b0; repeat (loT) tick();
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired: got timeout expected completion");
    finishRun();
  end

  initial begin
    rst = 1; refClkIn = 0; dllRun = 0; freqChange = 0; readCycle = 0;
    repeat (3) tick();
    settle();
    check("R9 reset lockReady", lockReady, 1'b0);
    check("R9 reset cmdEnable", cmdEnable, 1'b0);
    check("R9 reset impCalDone", impCalDone, 1'b0);
    check("R5 reset periodTooLong", periodTooLong, 1'b0);
    tick(); rst = 0;

    // loop disabled; reads first, then quiet cycles
    readCycle = 1; refCycles(600, 1, 1);
    readCycle = 0; refCycles(900, 1, 1);
    settle();
    check("R1 disabled no lock", lockReady, 1'b0);
    check("R6 reads not counted", impCalDone, 1'b0);

    // enable and lock
    tick(); dllRun = 1;
    refCycles(1000, 1, 1);
    settle();
    check("R2 not yet locked", lockReady, 1'b0);
    check("R6 quiet cycles settle impedance", impCalDone, 1'b1);
    refCycles(100, 1, 1);
    settle();
    check("R2 locked after 1024", lockReady, 1'b1);
    check("R8 commands enabled", cmdEnable, 1'b1);
    refCycles(200, 1, 1);
    settle();
    check("R2 saturated lock holds", lockReady, 1'b1);

    // disable for one cycle
    tick(); dllRun = 0;
    settle();
    check("R8 command gate drops with disable", cmdEnable, 1'b0);
    tick(); dllRun = 1;
    settle();
    check("R1 disable cleared lock", lockReady, 1'b0);
    refCycles(1100, 1, 1);
    settle();
    check("R1 relock after enable", lockReady, 1'b1);

    // frequency change
    refClkIn = 1; freqChange = 1; tick(); freqChange = 0;
    settle();
    check("R4 freq change drops lock", lockReady, 1'b0);
    refClkIn = 0; tick();
    refCycles(1000, 1, 1);
    settle();
    check("R4 relock needs full count", lockReady, 1'b0);
    refCycles(100, 1, 1);
    settle();
    check("R4 relocked", lockReady, 1'b1);

    // clock stop
    refClkIn = 0; repeat (14) tick();
    settle();
    check("R3 stopped clock drops lock", lockReady, 1'b0);
    check("R6 impedance kept over stop", impCalDone, 1'b1);
    refCycles(1100, 1, 1);
    settle();
    check("R3 relock after restart", lockReady, 1'b1);

    // slow clock
    refCycles(40, 2, 2);
    settle();
    check("R7 slow period flagged", periodTooLong, 1'b1);
    check("R7 slow period blocks lock", lockReady, 1'b0);
    refCycles(1100, 1, 1);
    settle();
    check("R7 flag clears at fast period", periodTooLong, 1'b0);
    check("R7 relock after slow clock", lockReady, 1'b1);

    tick();
    finishRun();
  end
endmodule